// File: doc/BRIEF.md
# Clock-Timed Bus Target Controller

This block sits on the peripheral side of a processor bus that has no read or write strobes. Every transfer is timed by the processor clock alone. A cycle opens when the active-low address strobe is low at a rising edge. On that edge the target captures the word address, the direction, the DMA and lock flags and a 2-bit burst length. If the upper address bits select this target, it counts clocks from the capture edge to find the edge on which the processor expects data. It then presents read data, or takes write data, on that edge and on each edge of the burst that follows.

The target serves a small internal register array. A fixed number of wait states, set by a parameter, delays the first word of every cycle. Later burst words follow one per clock, and the two lowest address bits step with wrap-around. The processor may also overlap cycles by strobing the next address while the current data is still moving. The target holds one such pending cycle and starts it as soon as the current cycle ends. A further strobe that arrives while that slot is full is dropped and reported as a protocol error.

Top module: `sbt_target`

## Requirements
- R1: A cycle starts only when `ads_ni` is low at a rising edge and `addr_i[7:4]` equals the upper four bits of `BASE_ADDR`. A strobe with any other address gives no `ready_o` and writes nothing.
- R2: The first word of a cycle transfers in the (`WAIT_ST`+1)-th clock after the capture edge. `ready_o` stays low in the `WAIT_ST` clocks before that.
- R3: During a read clock with `ready_o` high, `rdata_o` holds the array word at the current address. At all other times `rdata_o` is zero.
- R4: During a write clock with `ready_o` high, `wdata_i` is stored at the current word address on the rising edge that ends that clock.
- R5: `blen_i` gives the burst length as the encoded value plus one, so 0 means 1 word and 3 means 4 words. Words after the first transfer on consecutive clocks with no wait states.
- R6: Within a burst, the two lowest address bits increment modulo 4 from the starting word, and the upper address bits stay fixed.
- R7: A selected strobe captured during the data phase of a cycle is held as pending. If it arrives in the last data clock of a cycle, its own timing starts on the very next clock, so with `WAIT_ST`=0 one word moves on every clock.
- R8: A selected strobe that arrives while a pending cycle is already held, and the current cycle is not in its last data clock, raises `perr_o` for exactly one clock and is discarded. The pending cycle still completes.
- R9: While a cycle is in progress, `lock_o` and `dma_o` carry the lock and DMA flags captured for that cycle. They are low when the target is idle.
- R10: After reset, `ready_o`, `perr_o`, `lock_o`, `dma_o` and `rdata_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_ni | input | 1 | Address strobe, active low |
| addr_i | input | 8 | Word address |
| wr_i | input | 1 | 1 = write, 0 = read |
| dma_i | input | 1 | DMA cycle flag |
| lock_i | input | 1 | Locked cycle flag |
| blen_i | input | 2 | Burst length minus one |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not driving |
| ready_o | output | 1 | Data transfers on the edge ending this clock |
| lock_o | output | 1 | Lock flag of the cycle in progress |
| dma_o | output | 1 | DMA flag of the cycle in progress |
| perr_o | output | 1 | One-clock pulse: overlapped strobe dropped |

## Verification
The hardest case to reach from the ports is the dropped third strobe. It needs a wait-stated target, so that the current cycle is still counting, and two further strobes held low on consecutive edges right after the capture edge. The bench drives exactly that on an instance with two wait states. It checks the error pulse, the late completion of the held cycle, and a later read-back showing that the dropped write never landed. A second, zero-wait instance at a different base address is used for back-to-back overlapped cycles and for a strobe placed in the last clock of a burst.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  parameter int unsigned SBT_AW = 8;

  typedef struct packed {
    logic [SBT_AW-1:0] addr;
    logic              wr;
    logic              dma;
    logic              lock;
    logic [1:0]        blen;
  } cyc_t;
endpackage

// File: rtl/sbt_capture.sv
module sbt_capture
  import sbt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ads_ni,
  input  logic sel_i,
  input  cyc_t cyc_i,
  input  logic busy_i,
  input  logic done_i,
  output logic start_o,
  output cyc_t start_cyc_o,
  output logic pend_o,
  output logic perr_o
);
  logic hit, free;
  logic pend_v_q;
  cyc_t pend_q;
  logic perr_q;

  assign hit  = !ads_ni && sel_i;
  assign free = !busy_i || done_i;

  // held cycle has priority over a fresh strobe
  assign start_o     = free && (pend_v_q || hit);
  assign start_cyc_o = pend_v_q ? pend_q : cyc_i;
  assign pend_o      = pend_v_q;
  assign perr_o      = perr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
      perr_q   <= 1'b0;
    end else begin
      perr_q <= hit && !free && pend_v_q;
      if (free) begin
        pend_v_q <= pend_v_q && hit;
        if (pend_v_q && hit) pend_q <= cyc_i;
      end else if (hit && !pend_v_q) begin
        pend_v_q <= 1'b1;
        pend_q   <= cyc_i;
      end
    end
  end

  // R8
  perr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> $past(pend_v_q));
endmodule

// File: rtl/sbt_seq.sv
module sbt_seq
  import sbt_pkg::*;
#(
  parameter int unsigned WAIT_ST = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  cyc_t start_cyc_i,
  output logic busy_o,
  output logic ready_o,
  output logic done_o,
  output cyc_t cur_o
);
  localparam int unsigned WCW = (WAIT_ST > 0) ? $clog2(WAIT_ST + 1) : 1;
  localparam logic [WCW-1:0] WLOAD = WCW'(WAIT_ST);

  logic           act_q;
  cyc_t           cur_q;
  logic [1:0]     rem_q;
  logic [WCW-1:0] wcnt_q;

  assign busy_o  = act_q;
  assign ready_o = act_q && (wcnt_q == '0);
  assign done_o  = ready_o && (rem_q == 2'd0);
  assign cur_o   = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cur_q  <= '0;
      rem_q  <= '0;
      wcnt_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      cur_q  <= start_cyc_i;
      rem_q  <= start_cyc_i.blen;
      wcnt_q <= WLOAD;
    end else if (act_q) begin
      if (wcnt_q != '0) begin
        wcnt_q <= wcnt_q - 1'b1;
      end else if (rem_q == 2'd0) begin
        act_q <= 1'b0;
      end else begin
        rem_q           <= rem_q - 2'd1;
        cur_q.addr[1:0] <= cur_q.addr[1:0] + 2'd1;
      end
    end
  end

  // R2
  first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ready_o == (WAIT_ST == 0)));
  // R5
  burst_gapless_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rem_q != 2'd0) |=> ready_o);
  // R6
  burst_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rem_q != 2'd0) |=>
      (cur_q.addr[1:0] == $past(cur_q.addr[1:0]) + 2'd1) &&
      $stable(cur_q.addr[SBT_AW-1:2]));
endmodule

// File: rtl/sbt_regs.sv
module sbt_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/sbt_target.sv
module sbt_target
  import sbt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WAIT_ST = 2,
  parameter logic [SBT_AW-1:0] BASE_ADDR = 8'hA0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ads_ni,
  input  logic [SBT_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic              dma_i,
  input  logic              lock_i,
  input  logic [1:0]        blen_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              lock_o,
  output logic              dma_o,
  output logic              perr_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic sel, start, busy, done, pend, ready;
  cyc_t bus_cyc, start_cyc, cur;
  logic [DATA_W-1:0] mem_rd;

  assign sel     = addr_i[SBT_AW-1:IDX_W] == BASE_ADDR[SBT_AW-1:IDX_W];
  assign bus_cyc = '{addr: addr_i, wr: wr_i, dma: dma_i, lock: lock_i, blen: blen_i};

  sbt_capture i_capture (
    .clk_i, .rst_ni, .ads_ni,
    .sel_i       (sel),
    .cyc_i       (bus_cyc),
    .busy_i      (busy),
    .done_i      (done),
    .start_o     (start),
    .start_cyc_o (start_cyc),
    .pend_o      (pend),
    .perr_o      (perr_o)
  );

  sbt_seq #(.WAIT_ST(WAIT_ST)) i_seq (
    .clk_i, .rst_ni,
    .start_i     (start),
    .start_cyc_i (start_cyc),
    .busy_o      (busy),
    .ready_o     (ready),
    .done_o      (done),
    .cur_o       (cur)
  );

  sbt_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_regs (
    .clk_i,
    .we_i    (ready && cur.wr),
    .idx_i   (cur.addr[IDX_W-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (mem_rd)
  );

  assign ready_o = ready;
  assign rdata_o = (ready && !cur.wr) ? mem_rd : '0;
  assign lock_o  = busy && cur.lock;
  assign dma_o   = busy && cur.dma;

  // R1
  unselected_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_ni && !sel && !busy && !pend) |=> !busy);
endmodule

// File: tb/test_sbt_target.sv
module test_sbt_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ads_n = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, dma = 1'b0, lock = 1'b0;
  logic [1:0]  blen = '0;
  logic [31:0] wdata = '0;

  logic [31:0] rdata_a, rdata_b;
  logic ready_a, lock_a, dma_a, perr_a;
  logic ready_b, lock_b, dma_b, perr_b;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sbt_target #(.WAIT_ST(2), .BASE_ADDR(8'hA0)) i_sbt_target (
    .clk_i(clk), .rst_ni(rst_n), .ads_ni(ads_n), .addr_i(addr), .wr_i(wr),
    .dma_i(dma), .lock_i(lock), .blen_i(blen), .wdata_i(wdata),
    .rdata_o(rdata_a), .ready_o(ready_a), .lock_o(lock_a), .dma_o(dma_a),
    .perr_o(perr_a));

  sbt_target #(.WAIT_ST(0), .BASE_ADDR(8'hB0)) i_sbt_target_nw (
    .clk_i(clk), .rst_ni(rst_n), .ads_ni(ads_n), .addr_i(addr), .wr_i(wr),
    .dma_i(dma), .lock_i(lock), .blen_i(blen), .wdata_i(wdata),
    .rdata_o(rdata_b), .ready_o(ready_b), .lock_o(lock_b), .dma_o(dma_b),
    .perr_o(perr_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic bus(input logic a_n, input logic [7:0] a, input logic w,
                     input logic [1:0] bl, input logic lk, input logic dm);
    ads_n = a_n; addr = a; wr = w; blen = bl; lock = lk; dma = dm;
  endtask

  task automatic t_reset();
    chk("R10 ready_a", 32'(ready_a), 0);
    chk("R10 ready_b", 32'(ready_b), 0);
    chk("R10 perr", 32'({perr_a, perr_b}), 0);
    chk("R10 lock/dma", 32'({lock_a, dma_a, lock_b, dma_b}), 0);
    chk("R10 rdata_a", rdata_a, 0);
    chk("R10 rdata_b", rdata_b, 0);
  endtask

  // 4-word write burst from A2, two wait states
  task automatic t_write_burst();
    bus(0, 8'hA2, 1, 2'd3, 0, 0);
    for (int k = 0; k <= 6; k++) begin
      @(negedge clk);
      chk("R2 R5 write ready", 32'(ready_a), 32'(k >= 2 && k <= 5));
      if (k == 0) ads_n = 1'b1;
      if (k >= 2 && k <= 5) wdata = 32'h1000 + 32'(k - 2);
    end
  endtask

  // 4-word read burst from A0; wrap shows A0..A3 = 1002,1003,1000,1001
  task automatic t_read_burst();
    logic [31:0] exp_d [4] = '{32'h1002, 32'h1003, 32'h1000, 32'h1001};
    bus(0, 8'hA0, 0, 2'd3, 1, 1);
    for (int k = 0; k <= 6; k++) begin
      @(negedge clk);
      if (k == 0) ads_n = 1'b1;
      chk("R2 read ready", 32'(ready_a), 32'(k >= 2 && k <= 5));
      chk("R3 R4 R6 rdata", rdata_a, (k >= 2 && k <= 5) ? exp_d[k-2] : 32'h0);
      chk("R9 lock", 32'(lock_a), 32'(k <= 5));
      chk("R9 dma", 32'(dma_a), 32'(k <= 5));
    end
  endtask

  task automatic t_single_nowait();
    bus(0, 8'hB9, 1, 2'd0, 0, 0);
    @(negedge clk);
    chk("R2 nowait write ready", 32'(ready_b), 1);
    ads_n = 1'b1; wdata = 32'h55AA;
    @(negedge clk);
    chk("R5 single ends", 32'(ready_b), 0);
    bus(0, 8'hB9, 0, 2'd0, 0, 0);
    @(negedge clk);
    ads_n = 1'b1;
    chk("R3 nowait read", rdata_b, 32'h55AA);
    @(negedge clk);
    chk("R3 rdata idle zero", rdata_b, 0);
  endtask

  task automatic t_pipelined();
    for (int n = 0; n <= 5; n++) begin
      if (n > 0) @(negedge clk);
      if (n > 0) chk("R7 pipelined write ready", 32'(ready_b), 32'(n <= 4));
      if (n >= 1 && n <= 4) wdata = 32'hB000 + 32'(n - 1);
      if (n < 4) bus(0, 8'hB4 + 8'(n), 1, 2'd0, 0, 0); else ads_n = 1'b1;
    end
    for (int n = 0; n <= 5; n++) begin
      if (n > 0) @(negedge clk);
      if (n > 0) chk("R7 pipelined read", rdata_b, (n <= 4) ? 32'hB000 + 32'(n - 1) : 32'h0);
      if (n < 4) bus(0, 8'hB4 + 8'(n), 0, 2'd0, 0, 0); else ads_n = 1'b1;
    end
  endtask

  // strobe in last clock of a 2-word burst follows with no gap
  task automatic t_burst_then_overlap();
    bus(0, 8'hB4, 0, 2'd1, 0, 0);
    @(negedge clk);
    chk("R5 burst w0", rdata_b, 32'hB000);
    ads_n = 1'b1;
    @(negedge clk);
    chk("R5 R6 burst w1", rdata_b, 32'hB001);
    bus(0, 8'hB9, 0, 2'd0, 0, 0);
    @(negedge clk);
    ads_n = 1'b1;
    chk("R7 overlap follows", rdata_b, 32'h55AA);
    @(negedge clk);
    chk("R7 overlap ends", 32'(ready_b), 0);
  endtask

  task automatic t_protocol_error();
    wdata = 32'hDEAD;
    bus(0, 8'hA1, 0, 2'd0, 0, 0);
    for (int k = 0; k <= 8; k++) begin
      @(negedge clk);
      if (k == 0) bus(0, 8'hA3, 0, 2'd0, 0, 0);
      else if (k == 1) bus(0, 8'hA2, 1, 2'd0, 0, 0);
      else ads_n = 1'b1;
      if (k >= 2) begin
        chk("R8 perr pulse", 32'(perr_a), 32'(k == 2));
        chk("R8 ready", 32'(ready_a), 32'(k == 2 || k == 5));
      end
      if (k == 2) chk("R8 first data", rdata_a, 32'h1003);
      if (k == 5) chk("R8 pending completes", rdata_a, 32'h1001);
    end
    bus(0, 8'hA2, 0, 2'd0, 0, 0);
    for (int k = 0; k <= 2; k++) begin
      @(negedge clk);
      ads_n = 1'b1;
      if (k == 2) chk("R8 dropped write absent", rdata_a, 32'h1000);
    end
  endtask

  task automatic t_unselected();
    wdata = 32'hBAD0;
    bus(0, 8'hC0, 1, 2'd3, 1, 1);
    for (int k = 0; k <= 6; k++) begin
      @(negedge clk);
      ads_n = 1'b1;
      chk("R1 unselected ready", 32'({ready_a, ready_b}), 0);
      chk("R1 R9 unselected lock", 32'({lock_a, lock_b}), 0);
    end
    bus(0, 8'hA0, 0, 2'd0, 0, 0);
    for (int k = 0; k <= 2; k++) begin
      @(negedge clk);
      ads_n = 1'b1;
      if (k == 2) chk("R1 no write", rdata_a, 32'h1002);
    end
  endtask

  initial begin
    #1;
    t_reset();
    #10 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_single_nowait();
    t_pipelined();
    t_burst_then_overlap();
    t_protocol_error();
    t_unselected();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule